// File: doc/BRIEF.md
# LCD Scanline Timing and Status Controller

This block produces the line and frame timing of a tile-based LCD from a stream of CPU clock-cycle counts. Each step adds between 1 and 24 CPU cycles to a dot position within the current line. The block keeps a line counter that runs over 154 lines per frame. It places the display in one of four modes at fixed dot offsets, keeps a line-compare flag, and raises interrupt-request pulses for vertical blank and for the selectable status sources. A renderer uses the line-start strobe to draw each visible line.

A CPU-side register port reads the line counter and the status byte, and writes the compare value and the four source enables. The interrupt controller owns the request register. This block only sends it single-cycle set pulses.

Top module: `lcd_line_timer`

## Requirements
- R1: After reset the line counter reads 153, the compare register and the status byte read 0 (mode 00), and the strobe and request outputs are low.
- R2: A line lasts 456 CPU cycles. When the dot position plus the step count reaches 456 or more, the excess carries into the next line and the line counter advances modulo 154. The reset dot position is 455, so the first step of any size starts line 0.
- R3: When a line from 0 to 143 starts, the mode becomes 2 (status bits 1:0 = 10), the line-start strobe pulses, and status bit 2 is set if the new line equals the compare value and cleared otherwise.
- R4: On a visible line, a step that takes the dot position from below 80 to 80 or above enters mode 3 (11), and a step that takes it from below 252 to 252 or above enters mode 0 (00). On lines 144 to 153 these offsets leave the mode unchanged.
- R5: The start of line 144 enters mode 1 (01) and pulses the vertical-blank request. Mode 1 holds through line 153.
- R6: The status request pulses for one cycle when any enabled source fires: bit 5 at a visible line start, bit 6 at a visible line start whose compare flag is set, bit 3 on entering mode 0, bit 4 on entering mode 1.
- R7: Register address 0 reads the line counter and ignores writes. Address 1 reads and writes the compare value. Address 2 reads the status byte: only bits 6:3 take a write, bits 2:0 ignore writes, and bit 7 reads 0. Address 3 reads 0.
- R8: A register write in the same cycle as a timing event leaves that event's compare and request decisions on the values held before the write. The write takes effect in the next cycle.
- R9: A cycle without a step changes neither the line counter nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A step of CPU cycles is presented |
| step_cycles | input | 5 | Cycles in this step, 1 to 24 |
| reg_addr | input | 2 | Register select: 0 line, 1 compare, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ly_o | output | 8 | Current line counter |
| mode_o | output | 2 | Current mode field |
| line_start_o | output | 1 | One-cycle strobe at the start of a visible line |
| irq_vblank_o | output | 1 | One-cycle vertical-blank request |
| irq_stat_o | output | 1 | One-cycle status request |

## Verification
A CPU write to the compare or enable bits can fall in the same cycle as a line start or a mode-0 entry that uses those values. The bench attaches writes with changing data to steps at a fixed stride, so they land on every kind of event across three frames. Its model applies each write only after it has settled that step's compare flag and request, so any use of the new value shows up as a mismatch on the status request or on status bit 2.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'b00,
        MODE_VBLANK = 2'b01,
        MODE_SCAN   = 2'b10,
        MODE_XFER   = 2'b11
    } lcd_mode_e;

    localparam logic [1:0] ADDR_LINE    = 2'd0;
    localparam logic [1:0] ADDR_COMPARE = 2'd1;
    localparam logic [1:0] ADDR_STATUS  = 2'd2;

    // index into the 4-bit enable field (status bits 6:3)
    localparam int EN_HBL  = 0;  // status bit 3
    localparam int EN_VBL  = 1;  // status bit 4
    localparam int EN_SCAN = 2;  // status bit 5
    localparam int EN_CMP  = 3;  // status bit 6

endpackage

// File: rtl/lcd_dot_events.sv
module lcd_dot_events #(
    parameter int LINE_CYCLES = 456,
    parameter int SCAN_END    = 80,
    parameter int XFER_END    = 252,
    parameter int STEP_W      = 5,
    parameter int DOT_W       = 9
) (
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_cycles,
    input  logic [DOT_W-1:0]  dot_q,
    output logic [DOT_W-1:0]  dot_d,
    output logic              line_evt,
    output logic              scan_done_evt,
    output logic              xfer_done_evt
);
    localparam int SUM_W = DOT_W + 1;
    localparam logic [SUM_W-1:0] LINE_S = SUM_W'(LINE_CYCLES);
    localparam logic [SUM_W-1:0] SCAN_S = SUM_W'(SCAN_END);
    localparam logic [SUM_W-1:0] XFER_S = SUM_W'(XFER_END);

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] dot_ext;

    always_comb begin
        dot_ext       = SUM_W'(dot_q);
        sum           = dot_ext + SUM_W'(step_cycles);
        dot_d         = dot_q;
        line_evt      = 1'b0;
        scan_done_evt = 1'b0;
        xfer_done_evt = 1'b0;
        if (step_valid) begin
            if (sum >= LINE_S) begin
                line_evt = 1'b1;
                dot_d    = DOT_W'(sum - LINE_S);
            end else begin
                dot_d         = DOT_W'(sum);
                scan_done_evt = (dot_ext < SCAN_S) && (sum >= SCAN_S);
                xfer_done_evt = (dot_ext < XFER_S) && (sum >= XFER_S);
            end
        end
    end

endmodule

// File: rtl/lcd_req_merge.sv
module lcd_req_merge (
    input  logic       vis_start,
    input  logic       cmp_hit,
    input  logic       hbl_enter,
    input  logic       vbl_enter,
    input  logic [3:0] en,
    output logic       stat_req
);
    import lcd_tim_pkg::*;

    always_comb begin
        stat_req = (vis_start && en[EN_SCAN])
                 || (vis_start && cmp_hit && en[EN_CMP])
                 || (hbl_enter && en[EN_HBL])
                 || (vbl_enter && en[EN_VBL]);
    end

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
    parameter int LINE_CYCLES = 456,
    parameter int SCAN_END    = 80,
    parameter int XFER_END    = 252,
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154,
    parameter int STEP_W      = 5,
    parameter int LY_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_cycles,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [LY_W-1:0]   ly_o,
    output logic [1:0]        mode_o,
    output logic              line_start_o,
    output logic              irq_vblank_o,
    output logic              irq_stat_o
);
    import lcd_tim_pkg::*;

    localparam int DOT_W = $clog2(LINE_CYCLES);
    localparam logic [LY_W-1:0]  LY_LAST  = LY_W'(TOTAL_LINES - 1);
    localparam logic [LY_W-1:0]  LY_VIS   = LY_W'(VIS_LINES);
    localparam logic [DOT_W-1:0] DOT_INIT = DOT_W'(LINE_CYCLES - 1);

    typedef struct packed {
        logic [DOT_W-1:0] dot;
        logic [LY_W-1:0]  ly;
        logic [7:0]       cmp;
        logic [3:0]       en;
        logic             hit;
        lcd_mode_e        mode;
        logic             line_start;
        logic             irq_vbl;
        logic             irq_stat;
    } tim_state_t;

    tim_state_t s_q, s_d;

    logic [DOT_W-1:0] dot_d;
    logic             line_evt, scan_evt, xfer_evt;
    logic [LY_W-1:0]  ly_next;
    logic             vis_start, vbl_enter, old_vis;
    logic             hit_next, stat_req;

    lcd_dot_events #(
        .LINE_CYCLES(LINE_CYCLES),
        .SCAN_END   (SCAN_END),
        .XFER_END   (XFER_END),
        .STEP_W     (STEP_W),
        .DOT_W      (DOT_W)
    ) events_i (
        .step_valid   (step_valid),
        .step_cycles  (step_cycles),
        .dot_q        (s_q.dot),
        .dot_d        (dot_d),
        .line_evt     (line_evt),
        .scan_done_evt(scan_evt),
        .xfer_done_evt(xfer_evt)
    );

    always_comb begin
        ly_next   = line_evt ? ((s_q.ly == LY_LAST) ? '0 : s_q.ly + 1'b1) : s_q.ly;
        vis_start = line_evt && (ly_next < LY_VIS);
        vbl_enter = line_evt && (ly_next == LY_VIS);
        old_vis   = s_q.ly < LY_VIS;
        hit_next  = vis_start ? (8'(ly_next) == s_q.cmp) : s_q.hit;
    end

    lcd_req_merge req_i (
        .vis_start(vis_start),
        .cmp_hit  (hit_next),
        .hbl_enter(xfer_evt && old_vis),
        .vbl_enter(vbl_enter),
        .en       (s_q.en),
        .stat_req (stat_req)
    );

    always_comb begin
        s_d            = s_q;
        s_d.dot        = dot_d;
        s_d.ly         = ly_next;
        s_d.hit        = hit_next;
        s_d.line_start = vis_start;
        s_d.irq_vbl    = vbl_enter;
        s_d.irq_stat   = stat_req;
        if (vis_start)                  s_d.mode = MODE_SCAN;
        else if (vbl_enter)             s_d.mode = MODE_VBLANK;
        else if (scan_evt && old_vis)   s_d.mode = MODE_XFER;
        else if (xfer_evt && old_vis)   s_d.mode = MODE_HBLANK;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_COMPARE: s_d.cmp = reg_wdata;
                ADDR_STATUS:  s_d.en  = reg_wdata[6:3];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.dot        <= DOT_INIT;
            s_q.ly         <= LY_LAST;
            s_q.mode       <= MODE_HBLANK;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_LINE:    reg_rdata = 8'(s_q.ly);
            ADDR_COMPARE: reg_rdata = s_q.cmp;
            ADDR_STATUS:  reg_rdata = {1'b0, s_q.en, s_q.hit, s_q.mode};
            default:      reg_rdata = 8'h00;
        endcase
    end

    assign ly_o         = s_q.ly;
    assign mode_o       = s_q.mode;
    assign line_start_o = s_q.line_start;
    assign irq_vblank_o = s_q.irq_vbl;
    assign irq_stat_o   = s_q.irq_stat;

endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk #(
    parameter int LY_W        = 8,
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_valid,
    input logic [LY_W-1:0] ly_o,
    input logic [1:0]      mode_o,
    input logic            line_start_o,
    input logic            irq_vblank_o,
    input logic            irq_stat_o
);
    // R2
    ly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ly_o < LY_W'(TOTAL_LINES));

    // R9
    ly_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(ly_o));

    // R9
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(mode_o));

    // R3
    line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> (ly_o < LY_W'(VIS_LINES)) && (mode_o == 2'b10));

    // R5
    vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank_o |-> (ly_o == LY_W'(VIS_LINES)) && (mode_o == 2'b01));

    // R6
    stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat_o |-> $past(step_valid));

    // R5
    vblank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_vblank_o && line_start_o));

endmodule

bind lcd_line_timer lcd_line_timer_chk #(
    .LY_W       (LY_W),
    .VIS_LINES  (VIS_LINES),
    .TOTAL_LINES(TOTAL_LINES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (step_valid),
    .ly_o        (ly_o),
    .mode_o      (mode_o),
    .line_start_o(line_start_o),
    .irq_vblank_o(irq_vblank_o),
    .irq_stat_o  (irq_stat_o)
);

// File: tb/lcd_line_timer_tb_top.sv
`timescale 1ns/1ps
module lcd_line_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_valid;
    logic [4:0] step_cycles;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] ly_o;
    logic [1:0] mode_o;
    logic       line_start_o, irq_vblank_o, irq_stat_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // bench model
    int pos;
    int mode_m, hit_m, cmp_m, en_m;

    always #5 clk = ~clk;

    lcd_line_timer dut_i (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_cycles(step_cycles),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ly_o(ly_o), .mode_o(mode_o), .line_start_o(line_start_o),
        .irq_vblank_o(irq_vblank_o), .irq_stat_o(irq_stat_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int ly_of(int p);
        return (153 + p / 456) % 154;
    endfunction

    task automatic read_all(string tag);
        reg_wr = 1'b0; step_valid = 1'b0;
        reg_addr = 2'd2; #1;
        chk({tag, " R7 status"}, reg_rdata, (en_m << 3) | (hit_m << 2) | mode_m);
        reg_addr = 2'd0; #1;
        chk({tag, " R2 line"}, reg_rdata, ly_of(pos));
        reg_addr = 2'd1; #1;
        chk({tag, " R7 compare"}, reg_rdata, cmp_m);
        reg_addr = 2'd3; #1;
        chk({tag, " R7 spare"}, reg_rdata, 0);
        chk({tag, " R9 ly port"}, ly_o, ly_of(pos));
        chk({tag, " R4 mode port"}, mode_o, mode_m);
    endtask

    // one step with an optional same-cycle write (R8)
    task automatic do_step(int s, bit wr, int addr, int data);
        int p, q, oly, nly, pd, qd;
        bit lev, ls, vb, m3, m0, req;
        p = pos; q = pos + s;
        oly = ly_of(p); nly = ly_of(q);
        pd = p % 456; qd = q % 456;
        lev = (q / 456) > (p / 456);
        ls = lev && nly < 144;
        vb = lev && nly == 144;
        m3 = !lev && oly < 144 && pd < 80 && qd >= 80;
        m0 = !lev && oly < 144 && pd < 252 && qd >= 252;
        if (ls) hit_m = (nly == cmp_m) ? 1 : 0;
        req = (ls && en_m[2]) || (ls && hit_m == 1 && en_m[3]) || (m0 && en_m[0]) || (vb && en_m[1]);
        if (ls) mode_m = 2; else if (vb) mode_m = 1; else if (m3) mode_m = 3; else if (m0) mode_m = 0;
        step_valid = 1'b1; step_cycles = 5'(s);
        reg_wr = wr; reg_addr = 2'(addr); reg_wdata = 8'(data);
        @(posedge clk); @(negedge clk);
        pos = q;
        if (wr && addr == 1) cmp_m = data & 8'hFF;
        if (wr && addr == 2) en_m = (data >> 3) & 4'hF;
        chk("R3 line start strobe", line_start_o, ls);
        chk("R5 vblank request", irq_vblank_o, vb);
        chk("R6/R8 status request", irq_stat_o, req);
        read_all("step");
    endtask

    task automatic idle_write(int addr, int data);
        step_valid = 1'b0; reg_wr = 1'b1; reg_addr = 2'(addr); reg_wdata = 8'(data);
        @(posedge clk); @(negedge clk);
        if (addr == 1) cmp_m = data & 8'hFF;
        if (addr == 2) en_m = (data >> 3) & 4'hF;
        chk("R9 idle no strobe", line_start_o, 0);
        chk("R9 idle no request", irq_stat_o | irq_vblank_o, 0);
        read_all("idle");
    endtask

    initial begin
        rst_n = 1'b0; step_valid = 1'b0; step_cycles = '0;
        reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        pos = 455; mode_m = 0; hit_m = 0; cmp_m = 0; en_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1
        chk("R1 reset ly", ly_o, 153);
        chk("R1 reset strobe", line_start_o, 0);
        chk("R1 reset vblank", irq_vblank_o, 0);
        chk("R1 reset stat irq", irq_stat_o, 0);
        read_all("R1 reset");
        // R7: line register ignores writes, status low bits ignore writes
        idle_write(0, 8'h55);
        idle_write(2, 8'hFF);
        idle_write(1, 8'd0);
        for (int i = 0; i < 17000; i++) begin
            int s;
            s = 1 + ((i * 7 + i / 24) % 24);
            if (i % 29 == 0)       do_step(s, 1'b1, 1, (i / 29) % 150);
            else if (i % 29 == 13) do_step(s, 1'b1, 2, (i * 37) ^ 8'h5A);
            else if (i % 29 == 21) do_step(s, 1'b1, 0, i);
            else                   do_step(s, 1'b0, 0, 0);
            if (i % 101 == 50) idle_write(2, i ^ 8'h27);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule